// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Receiver with Run Expansion

This block is the host end of an enhanced-capability parallel port while the peripheral is sending. On request it turns the bus from forward to reverse, then takes bytes from the peripheral one at a time. For each byte the peripheral pulls nAck low. The host acknowledges by raising nAutoFd until nAck returns high, and then drops nAutoFd again. The Busy line, sampled with the byte, tells payload apart from commands. A payload byte goes out on a valid/ready byte stream. A command byte either selects a channel, which this receiver discards, or carries a repeat count that makes the next payload byte come out several times.

A read request names how many output bytes are wanted. The read ends when that many bytes have been accepted downstream, when the peripheral stays silent for the idle window, or when a handshake response is late. Repeats that a read did not consume stay pending for the next read. A second request turns the bus back to forward. That mode change, like reset, drops any pending repeat state. All timing windows are counted in clock cycles and set by parameters.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset the port is in forward mode: the data bus is driven by the host (`pd_dir_in_o`=0), nStrobe, nAutoFd, nInit and nSelectIn are all high, and `out_valid_o` is low.
- R2: A `rev_go` pulse in forward mode first switches the bus to input and drives nAutoFd low, with nInit still high. After SETUP_CYC cycles it drives nInit low. The turnaround completes with an `op_done_o` pulse as soon as PError is seen low.
- R3: If PError stays high for RESP_CYC cycles during the reverse turnaround, `op_done_o` and `rsp_tmo_o` pulse together and the port stays in reverse mode.
- R4: A byte taken while nAck is low and Busy is high is payload. It appears unchanged on `out_data_o`, and `out_valid_o` holds with stable data until `out_ready_i` is high.
- R5: After each received byte, nAutoFd goes high until nAck returns high, then goes low again. If nAck stays low for RESP_CYC cycles, the read ends with `op_done_o` and `rsp_tmo_o`, and nAutoFd returns low.
- R6: A byte taken while Busy is low and bit 7 is 1 is a channel select. It is handshaken and produces no output.
- R7: A byte taken while Busy is low and bit 7 is 0 is a repeat count n in bits 6:0. The next payload byte is emitted n+1 times in total, with no bus byte accepted in between. A count of 0 emits the byte once.
- R8: When a read's byte count is used up partway through a run, the rest of the run is emitted first by the next read, before any bus byte is accepted.
- R9: If nAck is not seen low within IDLE_CYC cycles while a read waits for a byte, the read ends with `op_done_o` and `idle_exp_o`, without `rsp_tmo_o`. Bytes already emitted stay valid.
- R10: A `fwd_go` pulse in reverse mode raises nInit while nAutoFd stays low and the bus stays input. Once PError is high, it raises nAutoFd, returns the bus to output and pulses `op_done_o`. Any pending repeat state is cleared.
- R11: `rev_go` in reverse mode, and `rd_go` or `fwd_go` in forward mode, have no effect. A `rd_go` with `rd_len`=0 in reverse mode completes at once with `op_done_o` and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rev_go | input | 1 | Pulse: turn the bus to reverse |
| fwd_go | input | 1 | Pulse: turn the bus to forward |
| rd_go | input | 1 | Pulse: start a read of `rd_len` output bytes |
| rd_len | input | LEN_W | Number of output bytes wanted by the read |
| pd_i | input | 8 | Parallel data bus as seen by the host |
| pd_dir_in_o | output | 1 | 1: host releases the data bus (reverse) |
| nstrobe_o | output | 1 | Host strobe line |
| nautofd_o | output | 1 | Host handshake line |
| ninit_o | output | 1 | Host reverse-request line |
| nselectin_o | output | 1 | Host select line |
| nack_i | input | 1 | Peripheral byte-present line (low active) |
| busy_i | input | 1 | Peripheral payload/command flag |
| perror_i | input | 1 | Peripheral turnaround acknowledge |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| op_done_o | output | 1 | Pulse: request finished |
| rsp_tmo_o | output | 1 | Pulse with `op_done_o`: response window expired |
| idle_exp_o | output | 1 | Pulse with `op_done_o`: idle window expired |

## Verification
The properties assume a peripheral that keeps the data bus and Busy steady while it holds nAck low. They also assume it releases nAck only after nAutoFd has risen, and changes PError only while a turnaround is in progress. Requests are assumed to be single-cycle pulses. The stimulus meets these assumptions with a peripheral model that drives byte, Busy and nAck low together on a falling clock edge. The model waits for nAutoFd to rise before releasing nAck, and moves PError only in response to nInit. The only deliberate violations of protocol timing are the late nAck release and the late or missing PError. They are used to reach the timeout paths.

// File: rtl/ecprx_pkg.sv
package ecprx_pkg;

    typedef enum logic [3:0] {
        ST_FWD,
        ST_RT_SETUP,
        ST_RT_PE,
        ST_REV,
        ST_DECIDE,
        ST_WACK,
        ST_EMIT,
        ST_HSK,
        ST_RPT,
        ST_FT_PE
    } rx_state_e;

    typedef enum logic [1:0] {
        BK_DATA,
        BK_CHAN,
        BK_RUN
    } beat_kind_e;

    typedef struct packed {
        beat_kind_e kind;
        logic [7:0] val;
    } beat_t;

    typedef struct packed {
        logic nstrobe;
        logic nautofd;
        logic ninit;
        logic nselectin;
        logic dir_in;
    } pins_t;

    localparam int unsigned CHAN_BIT = 7;
    localparam int unsigned RUN_W    = 7;

    function automatic beat_kind_e classify(input logic busy, input logic [7:0] v);
        if (busy)
            return BK_DATA;
        else if (v[CHAN_BIT])
            return BK_CHAN;
        else
            return BK_RUN;
    endfunction

    function automatic pins_t pins_for(input rx_state_e s);
        pins_t p;
        p.nstrobe   = 1'b1;
        p.nselectin = 1'b1;
        case (s)
            ST_FWD:      begin p.nautofd = 1'b1; p.ninit = 1'b1; p.dir_in = 1'b0; end
            ST_RT_SETUP: begin p.nautofd = 1'b0; p.ninit = 1'b1; p.dir_in = 1'b1; end
            ST_HSK:      begin p.nautofd = 1'b1; p.ninit = 1'b0; p.dir_in = 1'b1; end
            ST_FT_PE:    begin p.nautofd = 1'b0; p.ninit = 1'b1; p.dir_in = 1'b1; end
            default:     begin p.nautofd = 1'b0; p.ninit = 1'b0; p.dir_in = 1'b1; end
        endcase
        return p;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ecprx_timer.sv
module ecprx_timer #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (cnt_q != {W{1'b1}})
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == (limit - W'(1)));

endmodule

// File: rtl/ecprx_rle.sv
module ecprx_rle
    import ecprx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_run,
    input  logic [RUN_W-1:0] run_val,
    input  logic             load_data,
    input  logic [7:0]       data_val,
    input  logic             dec,
    output logic             pending,
    output logic             armed,
    output logic [RUN_W-1:0] cnt,
    output logic [7:0]       rbyte
);

    logic [RUN_W-1:0] cnt_q;
    logic             armed_q;
    logic [7:0]       byte_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            byte_q  <= '0;
        end else if (load_run) begin
            cnt_q   <= run_val;
            armed_q <= 1'b1;
        end else if (load_data) begin
            byte_q  <= data_val;
            armed_q <= 1'b0;
        end else if (dec && cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign pending = (cnt_q != '0) && !armed_q;
    assign armed   = armed_q;
    assign cnt     = cnt_q;
    assign rbyte   = byte_q;

endmodule

// File: rtl/ecprx_fsm.sv
module ecprx_fsm
    import ecprx_pkg::*;
#(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned TW        = 11,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned RESP_CYC  = 6,
    parameter int unsigned IDLE_CYC  = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rev_go,
    input  logic             fwd_go,
    input  logic             rd_go,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [7:0]       pd_i,
    input  logic             nack_i,
    input  logic             busy_i,
    input  logic             perror_i,
    input  logic             out_ready_i,
    input  logic             tmr_hit,
    input  logic             rle_pending,
    input  logic             rle_armed,
    input  logic [RUN_W-1:0] rle_cnt,
    input  logic [7:0]       rle_byte,
    output logic             tmr_clr,
    output logic [TW-1:0]    tmr_limit,
    output logic             rle_clr,
    output logic             rle_load_run,
    output logic [RUN_W-1:0] rle_run_val,
    output logic             rle_load_data,
    output logic [7:0]       rle_data_val,
    output logic             rle_dec,
    output pins_t            pins,
    output logic [7:0]       out_data_o,
    output logic             out_valid_o,
    output logic             op_done_o,
    output logic             rsp_tmo_o,
    output logic             idle_exp_o
);

    rx_state_e        state_q, state_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    beat_t            beat_q, beat_d;
    logic             done_d, tmo_d, idle_d;
    beat_kind_e       kind_now;

    assign kind_now = classify(busy_i, pd_i);

    always_comb begin
        case (state_q)
            ST_RT_SETUP: tmr_limit = TW'(SETUP_CYC);
            ST_WACK:     tmr_limit = TW'(IDLE_CYC);
            default:     tmr_limit = TW'(RESP_CYC);
        endcase
    end

    always_comb begin
        state_d       = state_q;
        rem_d         = rem_q;
        beat_d        = beat_q;
        done_d        = 1'b0;
        tmo_d         = 1'b0;
        idle_d        = 1'b0;
        rle_clr       = 1'b0;
        rle_load_run  = 1'b0;
        rle_load_data = 1'b0;
        rle_dec       = 1'b0;
        out_valid_o   = 1'b0;
        out_data_o    = beat_q.val;
        case (state_q)
            ST_FWD: begin
                if (rev_go) begin
                    state_d = ST_RT_SETUP;
                    rle_clr = 1'b1;
                end
            end
            ST_RT_SETUP: begin
                if (tmr_hit)
                    state_d = ST_RT_PE;
            end
            ST_RT_PE: begin
                if (!perror_i) begin
                    state_d = ST_REV;
                    done_d  = 1'b1;
                end else if (tmr_hit) begin
                    state_d = ST_REV;
                    done_d  = 1'b1;
                    tmo_d   = 1'b1;
                end
            end
            ST_REV: begin
                if (rd_go) begin
                    if (rd_len == '0) begin
                        done_d = 1'b1;
                    end else begin
                        rem_d   = rd_len;
                        state_d = ST_DECIDE;
                    end
                end else if (fwd_go) begin
                    state_d = ST_FT_PE;
                end
            end
            ST_DECIDE: begin
                if (rem_q == '0) begin
                    state_d = ST_REV;
                    done_d  = 1'b1;
                end else if (rle_pending) begin
                    state_d = ST_RPT;
                end else begin
                    state_d = ST_WACK;
                end
            end
            ST_WACK: begin
                if (!nack_i) begin
                    beat_d.kind = kind_now;
                    beat_d.val  = pd_i;
                    if (kind_now == BK_DATA) begin
                        state_d = ST_EMIT;
                    end else begin
                        rle_load_run = (kind_now == BK_RUN);
                        state_d      = ST_HSK;
                    end
                end else if (tmr_hit) begin
                    state_d = ST_REV;
                    done_d  = 1'b1;
                    idle_d  = 1'b1;
                end
            end
            ST_EMIT: begin
                out_valid_o = 1'b1;
                if (out_ready_i) begin
                    rem_d         = rem_q - 1'b1;
                    rle_load_data = rle_armed;
                    state_d       = ST_HSK;
                end
            end
            ST_HSK: begin
                if (nack_i) begin
                    state_d = ST_DECIDE;
                end else if (tmr_hit) begin
                    state_d = ST_REV;
                    done_d  = 1'b1;
                    tmo_d   = 1'b1;
                end
            end
            ST_RPT: begin
                out_valid_o = 1'b1;
                out_data_o  = rle_byte;
                if (out_ready_i) begin
                    rem_d   = rem_q - 1'b1;
                    rle_dec = 1'b1;
                    if (rle_cnt == RUN_W'(1) || rem_q == LEN_W'(1))
                        state_d = ST_DECIDE;
                end
            end
            ST_FT_PE: begin
                if (perror_i || tmr_hit) begin
                    state_d = ST_FWD;
                    done_d  = 1'b1;
                    tmo_d   = !perror_i;
                    rle_clr = 1'b1;
                end
            end
            default: state_d = ST_FWD;
        endcase
    end

    assign tmr_clr      = (state_d != state_q);
    assign rle_run_val  = pd_i[RUN_W-1:0];
    assign rle_data_val = beat_q.val;
    assign pins         = pins_for(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_FWD;
            rem_q      <= '0;
            beat_q     <= '{kind: BK_DATA, val: 8'h00};
            op_done_o  <= 1'b0;
            rsp_tmo_o  <= 1'b0;
            idle_exp_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            rem_q      <= rem_d;
            beat_q     <= beat_d;
            op_done_o  <= done_d;
            rsp_tmo_o  <= tmo_d;
            idle_exp_o <= idle_d;
        end
    end

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
    import ecprx_pkg::*;
#(
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned SETUP_CYC = 1,
    parameter int unsigned RESP_CYC  = 6,
    parameter int unsigned IDLE_CYC  = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rev_go,
    input  logic             fwd_go,
    input  logic             rd_go,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [7:0]       pd_i,
    output logic             pd_dir_in_o,
    output logic             nstrobe_o,
    output logic             nautofd_o,
    output logic             ninit_o,
    output logic             nselectin_o,
    input  logic             nack_i,
    input  logic             busy_i,
    input  logic             perror_i,
    output logic [7:0]       out_data_o,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic             op_done_o,
    output logic             rsp_tmo_o,
    output logic             idle_exp_o
);

    localparam int unsigned MAX_CYC = max3(SETUP_CYC, RESP_CYC, IDLE_CYC);
    localparam int unsigned TW      = $clog2(MAX_CYC + 1);

    logic             tmr_clr, tmr_hit;
    logic [TW-1:0]    tmr_limit;
    logic             rle_clr, rle_load_run, rle_load_data, rle_dec;
    logic             rle_pending, rle_armed;
    logic [RUN_W-1:0] rle_run_val, rle_cnt;
    logic [7:0]       rle_data_val, rle_byte;
    pins_t            pins;

    ecprx_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    ecprx_rle u_rle (
        .clk       (clk),
        .rst       (rst),
        .clr       (rle_clr),
        .load_run  (rle_load_run),
        .run_val   (rle_run_val),
        .load_data (rle_load_data),
        .data_val  (rle_data_val),
        .dec       (rle_dec),
        .pending   (rle_pending),
        .armed     (rle_armed),
        .cnt       (rle_cnt),
        .rbyte     (rle_byte)
    );

    ecprx_fsm #(
        .LEN_W     (LEN_W),
        .TW        (TW),
        .SETUP_CYC (SETUP_CYC),
        .RESP_CYC  (RESP_CYC),
        .IDLE_CYC  (IDLE_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .rev_go        (rev_go),
        .fwd_go        (fwd_go),
        .rd_go         (rd_go),
        .rd_len        (rd_len),
        .pd_i          (pd_i),
        .nack_i        (nack_i),
        .busy_i        (busy_i),
        .perror_i      (perror_i),
        .out_ready_i   (out_ready_i),
        .tmr_hit       (tmr_hit),
        .rle_pending   (rle_pending),
        .rle_armed     (rle_armed),
        .rle_cnt       (rle_cnt),
        .rle_byte      (rle_byte),
        .tmr_clr       (tmr_clr),
        .tmr_limit     (tmr_limit),
        .rle_clr       (rle_clr),
        .rle_load_run  (rle_load_run),
        .rle_run_val   (rle_run_val),
        .rle_load_data (rle_load_data),
        .rle_data_val  (rle_data_val),
        .rle_dec       (rle_dec),
        .pins          (pins),
        .out_data_o    (out_data_o),
        .out_valid_o   (out_valid_o),
        .op_done_o     (op_done_o),
        .rsp_tmo_o     (rsp_tmo_o),
        .idle_exp_o    (idle_exp_o)
    );

    assign pd_dir_in_o = pins.dir_in;
    assign nstrobe_o   = pins.nstrobe;
    assign nautofd_o   = pins.nautofd;
    assign ninit_o     = pins.ninit;
    assign nselectin_o = pins.nselectin;

endmodule

// File: rtl/ecprx_chk.sv
module ecprx_chk (
    input logic       clk,
    input logic       rst,
    input logic       pd_dir_in_o,
    input logic       nautofd_o,
    input logic       ninit_o,
    input logic [7:0] out_data_o,
    input logic       out_valid_o,
    input logic       out_ready_i,
    input logic       op_done_o,
    input logic       rsp_tmo_o,
    input logic       idle_exp_o
);

    // R1: nothing is offered downstream while the host owns the bus
    a_r1_fwd_silent: assert property (@(posedge clk) disable iff (rst)
        !pd_dir_in_o |-> !out_valid_o);

    // R2: releasing the bus happens with nAutoFd low and nInit not yet low
    a_r2_turn_order: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_dir_in_o) |-> (!nautofd_o && ninit_o));

    // R3: a response timeout always closes the request
    a_r3_tmo_closes: assert property (@(posedge clk) disable iff (rst)
        rsp_tmo_o |-> op_done_o);

    // R4: an offered byte is held until taken
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R5: bytes are only offered while the handshake line is low in reverse mode
    a_r5_emit_low: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (pd_dir_in_o && !nautofd_o));

    // R9: a read ends for one reason only
    a_r9_one_reason: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_tmo_o, idle_exp_o}));

    // R9: idle expiry always closes the read
    a_r9_idle_closes: assert property (@(posedge clk) disable iff (rst)
        idle_exp_o |-> op_done_o);

    // R10: taking the bus back leaves both host lines high
    a_r10_fwd_release: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_dir_in_o) |-> (nautofd_o && ninit_o));

endmodule

bind ecp_rev_rx ecprx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_dir_in_o (pd_dir_in_o),
    .nautofd_o   (nautofd_o),
    .ninit_o     (ninit_o),
    .out_data_o  (out_data_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .op_done_o   (op_done_o),
    .rsp_tmo_o   (rsp_tmo_o),
    .idle_exp_o  (idle_exp_o)
);

// File: tb/sim_ecp_rev_rx.sv
module sim_ecp_rev_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rev_go = 1'b0, fwd_go = 1'b0, rd_go = 1'b0;
    logic [15:0] rd_len = '0;
    logic [7:0]  pd = '0;
    logic        nack = 1'b1, busy = 1'b0, perror = 1'b1;
    logic        out_ready = 1'b1;
    logic        dir_in, nstrobe, nautofd, ninit, nselectin;
    logic [7:0]  out_data;
    logic        out_valid, op_done, rsp_tmo, idle_exp;

    int checks = 0, errors = 0;
    int n_done = 0, n_tmo = 0, n_idle = 0, ngot = 0;
    logic [7:0] got [64];

    always #2 clk = ~clk;

    ecp_rev_rx u0 (
        .clk(clk), .rst(rst), .rev_go(rev_go), .fwd_go(fwd_go), .rd_go(rd_go),
        .rd_len(rd_len), .pd_i(pd), .pd_dir_in_o(dir_in), .nstrobe_o(nstrobe),
        .nautofd_o(nautofd), .ninit_o(ninit), .nselectin_o(nselectin),
        .nack_i(nack), .busy_i(busy), .perror_i(perror), .out_data_o(out_data),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .op_done_o(op_done),
        .rsp_tmo_o(rsp_tmo), .idle_exp_o(idle_exp)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready && ngot < 64) begin
                got[ngot] <= out_data;
                ngot <= ngot + 1;
            end
            if (op_done) n_done <= n_done + 1;
            if (rsp_tmo) n_tmo <= n_tmo + 1;
            if (idle_exp) n_idle <= n_idle + 1;
        end
    end

    // {busy, byte} per beat, and the bytes expected downstream
    localparam logic [8:0] BEATS [8] = '{
        {1'b1, 8'h11}, {1'b0, 8'h85}, {1'b1, 8'h22}, {1'b0, 8'h03},
        {1'b1, 8'h5A}, {1'b0, 8'h00}, {1'b1, 8'h77}, {1'b1, 8'hFF}
    };
    localparam logic [7:0] EXPV [8] = '{
        8'h11, 8'h22, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h77, 8'hFF
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_autofd(input logic lvl);
        for (int i = 0; i < 200; i++) begin
            if (nautofd == lvl) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_done(input int d0, input int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (n_done != d0) break;
            @(negedge clk);
        end
    endtask

    task automatic start_read(input int len);
        @(negedge clk); rd_len = 16'(len); rd_go = 1'b1;
        @(negedge clk); rd_go = 1'b0;
    endtask

    task automatic send_beat(input logic b, input logic [7:0] v);
        @(negedge clk); pd = v; busy = b; nack = 1'b0;
        wait_autofd(1'b1);
        nack = 1'b1;
        @(negedge clk);
        wait_autofd(1'b0);
    endtask

    task automatic go_reverse();
        int d0;
        d0 = n_done;
        @(negedge clk); rev_go = 1'b1;
        @(negedge clk); rev_go = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (!ninit) break;
            @(negedge clk);
        end
        perror = 1'b0;
        wait_done(d0, 50);
    endtask

    task automatic go_forward();
        int d0;
        d0 = n_done;
        @(negedge clk); fwd_go = 1'b1;
        @(negedge clk); fwd_go = 1'b0; perror = 1'b1;
        wait_done(d0, 50);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d0, t0, i0, g0;
        cyc(5);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 dir", dir_in, 0);
        chk("R1 lines", {nstrobe, nautofd, ninit, nselectin}, 4'hF);
        chk("R1 valid", out_valid, 0);

        // R11 read request in forward mode is ignored
        d0 = n_done;
        start_read(3);
        cyc(10);
        chk("R11 fwd read ignored", n_done - d0, 0);
        chk("R11 fwd read dir", dir_in, 0);

        // R2 reverse turnaround sequence
        d0 = n_done; t0 = n_tmo;
        @(negedge clk); rev_go = 1'b1;
        @(negedge clk); rev_go = 1'b0;
        chk("R2 first step", {dir_in, nautofd, ninit}, 3'b101);
        @(negedge clk);
        chk("R2 ninit low", {dir_in, nautofd, ninit}, 3'b100);
        perror = 1'b0;
        wait_done(d0, 50);
        chk("R2 done", n_done - d0, 1);
        chk("R2 no timeout", n_tmo - t0, 0);

        // R11 rev request while already reverse, and zero-length read
        d0 = n_done;
        @(negedge clk); rev_go = 1'b1;
        @(negedge clk); rev_go = 1'b0;
        cyc(5);
        chk("R11 rev ignored", {n_done - d0 == 0, ninit, dir_in}, 3'b101);
        g0 = ngot; d0 = n_done;
        start_read(0);
        cyc(3);
        chk("R11 len0 done", n_done - d0, 1);
        chk("R11 len0 no output", ngot - g0, 0);

        // R4 R6 R7 table-driven read
        g0 = ngot; d0 = n_done;
        start_read(8);
        for (int k = 0; k < 8; k++) send_beat(BEATS[k][8], BEATS[k][7:0]);
        wait_done(d0, 100);
        chk("R6 channel byte dropped, count", ngot - g0, 8);
        for (int k = 0; k < 8; k++) chk("R7 stream byte", got[g0 + k], EXPV[k]);

        // R4 backpressure holds data
        g0 = ngot; d0 = n_done;
        out_ready = 1'b0;
        start_read(1);
        @(negedge clk); pd = 8'hC3; busy = 1'b1; nack = 1'b0;
        cyc(5);
        chk("R4 held valid", {out_valid, nautofd}, 2'b10);
        chk("R4 held data", out_data, 8'hC3);
        cyc(3);
        chk("R4 still held", {out_valid, out_data}, {1'b1, 8'hC3});
        out_ready = 1'b1;
        wait_autofd(1'b1);
        nack = 1'b1;
        wait_done(d0, 50);
        chk("R4 accepted", {ngot - g0 == 1, got[g0]}, {1'b1, 8'hC3});

        // R5 late nAck release
        d0 = n_done; t0 = n_tmo;
        start_read(1);
        @(negedge clk); pd = 8'h10; busy = 1'b1; nack = 1'b0;
        wait_autofd(1'b1);
        chk("R5 autofd raised", nautofd, 1);
        cyc(20);
        chk("R5 timeout", n_tmo - t0, 1);
        chk("R5 autofd low again", nautofd, 0);
        nack = 1'b1;
        cyc(2);

        // R8 leftover run carried into next read
        g0 = ngot; d0 = n_done;
        start_read(3);
        send_beat(1'b0, 8'h04);
        send_beat(1'b1, 8'hA5);
        wait_done(d0, 50);
        chk("R8 first read count", ngot - g0, 3);
        chk("R8 first read bytes", {got[g0], got[g0+1], got[g0+2]}, 24'hA5A5A5);
        g0 = ngot; d0 = n_done;
        start_read(4);
        send_beat(1'b1, 8'h33);
        send_beat(1'b1, 8'h44);
        wait_done(d0, 50);
        chk("R8 second read count", ngot - g0, 4);
        chk("R8 second read bytes", {got[g0], got[g0+1], got[g0+2], got[g0+3]},
            32'hA5A53344);

        // R9 idle expiry
        g0 = ngot; d0 = n_done; t0 = n_tmo; i0 = n_idle;
        start_read(2);
        send_beat(1'b1, 8'h21);
        wait_done(d0, 3000);
        chk("R9 idle flag", n_idle - i0, 1);
        chk("R9 no rsp timeout", n_tmo - t0, 0);
        chk("R9 partial output", {ngot - g0 == 1, got[g0]}, {1'b1, 8'h21});

        // R10 forward turnaround clears run state
        d0 = n_done;
        start_read(1);
        send_beat(1'b0, 8'h05);
        send_beat(1'b1, 8'h66);
        wait_done(d0, 50);
        d0 = n_done; t0 = n_tmo;
        @(negedge clk); fwd_go = 1'b1;
        @(negedge clk); fwd_go = 1'b0;
        chk("R10 ninit high first", {dir_in, nautofd, ninit}, 3'b101);
        perror = 1'b1;
        wait_done(d0, 50);
        @(negedge clk);
        chk("R10 forward lines", {dir_in, nautofd, ninit}, 3'b011);
        chk("R10 no timeout", n_tmo - t0, 0);
        go_reverse();
        g0 = ngot; d0 = n_done;
        start_read(1);
        send_beat(1'b1, 8'h12);
        wait_done(d0, 50);
        chk("R10 run cleared", {ngot - g0 == 1, got[g0]}, {1'b1, 8'h12});

        // R3 reverse turnaround without PError response
        go_forward();
        d0 = n_done; t0 = n_tmo;
        @(negedge clk); rev_go = 1'b1;
        @(negedge clk); rev_go = 1'b0;
        wait_done(d0, 50);
        cyc(1);
        chk("R3 timeout flag", n_tmo - t0, 1);
        chk("R3 stays reverse", {dir_in, ninit}, 2'b10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule